// File: doc/BRIEF.md
# Shift-Register Packet Handshake Engine

This block moves packet bytes between a host and a device-side controller through one 8-bit shift register. The two sides pace each other with three active-low lines held in a handshake port. The host drives an acknowledge line and a transfer-in-progress line. The engine drives a request line that tells the host inbound bytes are waiting. A direction bit in a mode register selects the transfer direction: device to host (inbound) or host to device (outbound).

Inbound packets of up to 128 bytes are written into a local buffer through a byte write port and then committed together with their length. Each qualifying host handshake then pulls the next byte into the shift register. Outbound bytes that the host writes into the shift register are collected, one per qualifying handshake, into a 16-byte buffer. When the host drops the direction bit, the collected packet is offered for one cycle on a valid/length/data output. Every byte moved, and every new inbound packet, raises a shift-register flag. The host clears this flag itself. By convention, the first byte of each packet carries its type: 0 serial peripheral bus, 1 controller command, 2 error, 3 timer, 4 power. The engine carries this byte like any other and does not decode it.

Top module: `srx_engine`

## Requirements
- R1: After reset the handshake port reads 8'h38 (acknowledge bit 4, in-progress bit 5 and request bit 3 all high). The shift register, the flag, pkt_valid and rd_byte are all zero.
- R2: A byte moves only in a cycle where in-progress (port bit 5) is low and the pair {bit 4, bit 5} differs from its value in the previous cycle. Rewriting the same value, or toggling acknowledge while in-progress is high, moves nothing.
- R3: When mode bit 4 is 0, a qualifying handshake with unread inbound bytes loads the next inbound byte into the shift register, advances the read position and sets the flag. With no unread byte, it does nothing.
- R4: Port bit 3 (request) reads 0 while unread inbound bytes remain and 1 once they are drained.
- R5: When mode bit 4 is 1, each qualifying handshake appends the shift register to the outbound buffer and sets the flag.
- R6: Outbound bytes after the 16th are discarded, but each one still sets the flag.
- R7: A 1-to-0 change of mode bit 4 ends the outbound packet. If it holds at least one byte, pkt_valid pulses for exactly one cycle, starting the cycle after the mode write takes effect. During that cycle pkt_len gives the byte count and byte k sits at pkt_data[8k+7:8k]. The outbound count then restarts at zero. An empty packet produces no pulse.
- R8: ld_commit sets the inbound length to ld_len (capped at 128), returns the read position to the first byte and sets the flag. It takes priority over a handshake in the same cycle, so that handshake moves no byte.
- R9: rd_byte shows the inbound byte at the read position, or 8'h00 when no unread byte remains.
- R10: A host write to register 3 with data bit 2 set clears the flag. A flag-setting event in the same cycle wins over the clear.
- R11: A host write to register 2 loads the shift register. An inbound byte load in the same cycle takes priority over it. Register 0 is the handshake port and register 1 holds the direction in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Host register select: 0 port, 1 mode, 2 shift, 3 flag clear |
| wr_data | input | 8 | Host write data |
| ld_wr | input | 1 | Inbound buffer byte write |
| ld_addr | input | 7 | Inbound buffer byte position |
| ld_data | input | 8 | Inbound buffer byte value |
| ld_commit | input | 1 | Start a new inbound packet |
| ld_len | input | 8 | Inbound packet length in bytes |
| hs_port | output | 8 | Handshake port value with request on bit 3 |
| shift_q | output | 8 | Shift register contents |
| rd_byte | output | 8 | Inbound byte at the read position, or zero |
| sr_flag | output | 1 | Shift-register event flag |
| pkt_valid | output | 1 | One-cycle outbound packet strobe |
| pkt_len | output | 5 | Outbound packet length |
| pkt_data | output | 128 | Outbound packet bytes, byte k at bits 8k+7:8k |

## Verification
A three-byte inbound packet is drained with alternating acknowledge values. Interleaved with this are writes that repeat the port value and acknowledge toggles while in-progress is high. Together these separate a true pair-change detector from one that reacts to any write or ignores the in-progress gate. Outbound runs of 18 bytes, 2 bytes and 0 bytes show the overflow drop, the index restart and the empty-packet suppression. Deliberate same-cycle collisions separate each priority rule from its reversed version: a commit against a handshake, a handshake load against a host shift write, and a flag set against a clear.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;
  // Bit positions decoded by the host side of the handshake
  localparam int unsigned HS_REQ_BIT   = 3;
  localparam int unsigned HS_ACK_BIT   = 4;
  localparam int unsigned HS_TIP_BIT   = 5;
  localparam int unsigned DIR_BIT      = 4;
  localparam int unsigned FLAG_CLR_BIT = 2;

  typedef enum logic [1:0] {
    REG_PORT  = 2'd0,
    REG_MODE  = 2'd1,
    REG_SHIFT = 2'd2,
    REG_FLAG  = 2'd3
  } reg_sel_e;

  // pair = {ack, tip}; a handshake qualifies when tip is low and the pair moved
  function automatic logic hs_qualify(input logic [1:0] cur, input logic [1:0] prev);
    return (cur[0] == 1'b0) && (cur != prev);
  endfunction

  function automatic logic falling(input logic cur, input logic prev);
    return prev & ~cur;
  endfunction

  function automatic int unsigned clamp_len(input int unsigned req, input int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction
endpackage

// File: rtl/srx_edge.sv
`timescale 1ns/1ps
module srx_edge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pair,
  input  logic       dir,
  output logic       hs_evt,
  output logic       dir_fall
);
  logic [1:0] prev_pair_q;
  logic       prev_dir_q;

  // Previous-value copies refreshed every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pair_q <= 2'b11;
      prev_dir_q  <= 1'b0;
    end else begin
      prev_pair_q <= pair;
      prev_dir_q  <= dir;
    end
  end

  assign hs_evt   = srx_pkg::hs_qualify(pair, prev_pair_q);
  assign dir_fall = srx_pkg::falling(dir, prev_dir_q);
endmodule

// File: rtl/srx_inbuf.sv
`timescale 1ns/1ps
module srx_inbuf #(
  parameter  int unsigned DEPTH = 128,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_wr,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  input  logic          ld_commit,
  input  logic [CW-1:0] ld_len,
  input  logic          adv,
  output logic [7:0]    cur_byte,
  output logic          pending
);
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] len_q;
  logic [CW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (ld_wr) mem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      idx_q <= '0;
    end else if (ld_commit) begin
      len_q <= CW'(srx_pkg::clamp_len(int'(ld_len), DEPTH));
      idx_q <= '0;
    end else if (adv && pending) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign pending  = idx_q < len_q;
  assign cur_byte = pending ? mem[idx_q[AW-1:0]] : 8'h00;
endmodule

// File: rtl/srx_outbuf.sv
`timescale 1ns/1ps
module srx_outbuf #(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               store,
  input  logic [7:0]         byte_in,
  input  logic               pkt_end,
  output logic               pkt_valid,
  output logic [CW-1:0]      pkt_len,
  output logic [DEPTH*8-1:0] pkt_data,
  output logic [CW-1:0]      count
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  logic          room;

  assign room  = cnt_q < FULL;
  assign count = cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot_q <= 8'h00;
      else if (store && room && cnt_q == CW'(g))   slot_q <= byte_in;
    end
    assign pkt_data[g*8 +: 8] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pkt_valid <= 1'b0;
      pkt_len   <= '0;
    end else if (pkt_end) begin
      pkt_valid <= (cnt_q != '0);
      pkt_len   <= cnt_q;
      cnt_q     <= '0;
    end else begin
      pkt_valid <= 1'b0;
      if (store && room) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/srx_engine.sv
`timescale 1ns/1ps
module srx_engine #(
  parameter  int unsigned IN_DEPTH  = 128,
  parameter  int unsigned OUT_DEPTH = 16,
  localparam int unsigned IN_AW     = $clog2(IN_DEPTH),
  localparam int unsigned IN_CW     = $clog2(IN_DEPTH + 1),
  localparam int unsigned OUT_CW    = $clog2(OUT_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   ld_wr,
  input  logic [IN_AW-1:0]       ld_addr,
  input  logic [7:0]             ld_data,
  input  logic                   ld_commit,
  input  logic [IN_CW-1:0]       ld_len,
  output logic [7:0]             hs_port,
  output logic [7:0]             shift_q,
  output logic [7:0]             rd_byte,
  output logic                   sr_flag,
  output logic                   pkt_valid,
  output logic [OUT_CW-1:0]      pkt_len,
  output logic [OUT_DEPTH*8-1:0] pkt_data
);
  import srx_pkg::*;

  reg_sel_e          sel;
  logic [7:0]        port_q;
  logic              dir_q;
  logic [7:0]        sr_q;
  logic              flag_q;
  logic              hs_evt;
  logic              end_evt;
  logic              pending;
  logic [7:0]        cur_byte;
  logic              in_evt;
  logic              out_evt;
  logic [OUT_CW-1:0] out_cnt;

  assign sel = reg_sel_e'(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= 8'h30;
      dir_q  <= 1'b0;
    end else if (wr_en) begin
      if (sel == REG_PORT) port_q <= wr_data;
      if (sel == REG_MODE) dir_q  <= wr_data[DIR_BIT];
    end
  end

  srx_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pair     ({port_q[HS_ACK_BIT], port_q[HS_TIP_BIT]}),
    .dir      (dir_q),
    .hs_evt   (hs_evt),
    .dir_fall (end_evt)
  );

  // Named events for the checker; a commit takes the handshake's slot
  assign in_evt  = hs_evt & ~dir_q & pending & ~ld_commit;
  assign out_evt = hs_evt & dir_q;

  srx_inbuf #(.DEPTH(IN_DEPTH)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_wr     (ld_wr),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .ld_commit (ld_commit),
    .ld_len    (ld_len),
    .adv       (in_evt),
    .cur_byte  (cur_byte),
    .pending   (pending)
  );

  srx_outbuf #(.DEPTH(OUT_DEPTH)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .store     (out_evt),
    .byte_in   (sr_q),
    .pkt_end   (end_evt),
    .pkt_valid (pkt_valid),
    .pkt_len   (pkt_len),
    .pkt_data  (pkt_data),
    .count     (out_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                sr_q <= 8'h00;
    else if (in_evt)                           sr_q <= cur_byte;
    else if (wr_en && sel == REG_SHIFT)        sr_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                                 flag_q <= 1'b0;
    else if (in_evt || out_evt || ld_commit)                    flag_q <= 1'b1;
    else if (wr_en && sel == REG_FLAG && wr_data[FLAG_CLR_BIT]) flag_q <= 1'b0;
  end

  always_comb begin
    hs_port             = port_q;
    hs_port[HS_REQ_BIT] = ~pending;
  end

  assign shift_q = sr_q;
  assign rd_byte = cur_byte;
  assign sr_flag = flag_q;
endmodule

module srx_engine_chk #(
  parameter  int unsigned IN_DEPTH  = 128,
  parameter  int unsigned OUT_DEPTH = 16,
  localparam int unsigned IN_CW     = $clog2(IN_DEPTH + 1),
  localparam int unsigned OUT_CW    = $clog2(OUT_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        hs_port,
  input logic              sr_flag,
  input logic              pkt_valid,
  input logic [OUT_CW-1:0] pkt_len,
  input logic              ld_commit,
  input logic [IN_CW-1:0]  ld_len,
  input logic              in_evt,
  input logic              out_evt,
  input logic              end_evt,
  input logic [OUT_CW-1:0] out_cnt
);
  // R2
  tip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_port[5] |-> !in_evt && !out_evt);
  // R3
  in_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_evt |=> sr_flag);
  // R4
  req_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_commit && ld_len != '0) |=> !hs_port[3]);
  // R5
  out_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_evt |=> sr_flag);
  // R6
  out_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= OUT_CW'(OUT_DEPTH));
  // R7
  pkt_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> $past(end_evt) && pkt_len != '0);
  // R7
  pkt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid);
  // R8
  commit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_commit |=> sr_flag);
endmodule

bind srx_engine srx_engine_chk #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hs_port   (hs_port),
  .sr_flag   (sr_flag),
  .pkt_valid (pkt_valid),
  .pkt_len   (pkt_len),
  .ld_commit (ld_commit),
  .ld_len    (ld_len),
  .in_evt    (in_evt),
  .out_evt   (out_evt),
  .end_evt   (end_evt),
  .out_cnt   (out_cnt)
);

// File: tb/srx_engine_tb.sv
`timescale 1ns/1ps
module srx_engine_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = 2'd0;
  logic [7:0]   wr_data = 8'h00;
  logic         ld_wr = 1'b0;
  logic [6:0]   ld_addr = 7'd0;
  logic [7:0]   ld_data = 8'h00;
  logic         ld_commit = 1'b0;
  logic [7:0]   ld_len = 8'd0;
  logic [7:0]   hs_port, shift_q, rd_byte;
  logic         sr_flag, pkt_valid;
  logic [4:0]   pkt_len;
  logic [127:0] pkt_data;

  int total = 0;
  int bad = 0;
  bit armed = 0;
  bit done = 0;

  srx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ld_wr(ld_wr), .ld_addr(ld_addr), .ld_data(ld_data), .ld_commit(ld_commit), .ld_len(ld_len),
    .hs_port(hs_port), .shift_q(shift_q), .rd_byte(rd_byte), .sr_flag(sr_flag),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_data(pkt_data)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_port = 8'h30;
  logic [1:0] m_pair = 2'b11;
  bit  m_dir = 0, m_pdir = 0, m_flag = 0, m_pv = 0;
  int  m_sr = 0, m_len = 0, m_idx = 0, m_plen = 0;
  int  m_mem [128];
  int  m_out [$];
  int  m_pkt [$];

  always @(posedge clk) begin
    bit evt, fall, in_move, out_move;
    if (!rst_n) begin
      m_port = 8'h30; m_pair = 2'b11; m_dir = 0; m_pdir = 0; m_flag = 0; m_pv = 0;
      m_sr = 0; m_len = 0; m_idx = 0; m_plen = 0; m_out.delete(); m_pkt.delete();
    end else begin
      evt      = (m_port[5] == 1'b0) && ({m_port[4], m_port[5]} != m_pair);
      fall     = m_pdir && !m_dir;
      in_move  = evt && !m_dir && (m_idx < m_len) && !ld_commit;
      out_move = evt && m_dir;
      m_pv = 0;
      if (out_move && m_out.size() < 16) m_out.push_back(m_sr);
      if (fall) begin
        if (m_out.size() > 0) begin
          m_pv = 1; m_plen = m_out.size(); m_pkt = m_out;
        end
        m_out.delete();
      end
      if (in_move) m_sr = m_mem[m_idx];
      else if (wr_en && wr_addr == 2'd2) m_sr = wr_data;
      if (in_move || out_move || ld_commit) m_flag = 1;
      else if (wr_en && wr_addr == 2'd3 && wr_data[2]) m_flag = 0;
      if (ld_commit) begin
        m_idx = 0; m_len = (ld_len > 8'd128) ? 128 : int'(ld_len);
      end else if (in_move) m_idx++;
      if (ld_wr) m_mem[ld_addr] = ld_data;
      m_pair = {m_port[4], m_port[5]};
      m_pdir = m_dir;
      if (wr_en && wr_addr == 2'd0) m_port = wr_data;
      if (wr_en && wr_addr == 2'd1) m_dir = wr_data[4];
    end
  end

  // per-cycle comparison and packet capture
  int          got_cnt = 0;
  int          got_len = 0;
  logic [127:0] got_data = '0;

  always @(negedge clk) begin
    if (rst_n && armed) begin
      chk(hs_port == {m_port[7:4], (m_idx >= m_len), m_port[2:0]}, "R4", "model hs_port", hs_port, {m_port[7:4], (m_idx >= m_len), m_port[2:0]});
      chk(shift_q == 8'(m_sr), "R3", "model shift_q", shift_q, m_sr);
      chk(rd_byte == ((m_idx < m_len) ? 8'(m_mem[m_idx]) : 8'h00), "R9", "model rd_byte", rd_byte,
          (m_idx < m_len) ? m_mem[m_idx] : 0);
      chk(sr_flag == m_flag, "R10", "model flag", sr_flag, m_flag);
      chk(pkt_valid == m_pv, "R7", "model pkt_valid", pkt_valid, m_pv);
      if (m_pv && pkt_valid) begin
        chk(int'(pkt_len) == m_plen, "R7", "model pkt_len", pkt_len, m_plen);
        for (int i = 0; i < m_plen; i++)
          chk(pkt_data[i*8 +: 8] == 8'(m_pkt[i]), "R7", "model pkt byte", pkt_data[i*8 +: 8], m_pkt[i]);
      end
    end
    if (rst_n && pkt_valid) begin
      got_cnt++; got_len = pkt_len; got_data = pkt_data;
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] cur_port = 8'h30;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 2'd0) cur_port = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // flip acknowledge with in-progress low: always a qualifying change
  task automatic toggle_ack();
    host_wr(2'd0, (cur_port[4] || cur_port[5]) ? 8'h00 : 8'h10);
  endtask

  task automatic put_bytes(input int q[$]);
    foreach (q[i]) begin
      @(negedge clk);
      ld_wr = 1'b1; ld_addr = 7'(i); ld_data = 8'(q[i]);
    end
    @(negedge clk);
    ld_wr = 1'b0;
  endtask

  task automatic commit(input int n);
    @(negedge clk);
    ld_commit = 1'b1; ld_len = 8'(n);
    @(negedge clk);
    ld_commit = 1'b0;
  endtask

  task automatic clr_flag();
    host_wr(2'd3, 8'h04);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    int pk[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    armed = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hs_port == 8'h38, "R1", "reset hs_port", hs_port, 8'h38);
    chk(shift_q == 8'h00, "R1", "reset shift_q", shift_q, 0);
    chk(sr_flag == 1'b0, "R1", "reset flag", sr_flag, 0);
    chk(pkt_valid == 1'b0, "R1", "reset pkt_valid", pkt_valid, 0);
    chk(rd_byte == 8'h00, "R1", "reset rd_byte", rd_byte, 0);

    // inbound packet of three bytes, type 0 first
    put_bytes('{8'h00, 8'hA1, 8'hB2});
    commit(3);
    idle(1);
    chk(sr_flag == 1'b1, "R8", "flag after commit", sr_flag, 1);
    chk(hs_port[3] == 1'b0, "R4", "request low with data", hs_port[3], 0);
    chk(rd_byte == 8'h00, "R9", "first inbound byte", rd_byte, 0);
    clr_flag();
    idle(1);
    chk(sr_flag == 1'b0, "R10", "flag cleared", sr_flag, 0);

    host_wr(2'd0, 8'h10);
    idle(1);
    chk(shift_q == 8'h00, "R3", "byte0 loaded", shift_q, 0);
    chk(rd_byte == 8'hA1, "R3", "read pos advanced", rd_byte, 8'hA1);
    chk(sr_flag == 1'b1, "R3", "flag on inbound byte", sr_flag, 1);
    clr_flag();
    host_wr(2'd0, 8'h10);          // same value again
    idle(1);
    chk(rd_byte == 8'hA1, "R2", "repeat value no move", rd_byte, 8'hA1);
    chk(sr_flag == 1'b0, "R2", "repeat value no flag", sr_flag, 0);
    host_wr(2'd0, 8'h30);          // in-progress high
    host_wr(2'd0, 8'h20);          // ack change while in-progress high
    idle(1);
    chk(rd_byte == 8'hA1, "R2", "tip high no move", rd_byte, 8'hA1);
    host_wr(2'd0, 8'h00);
    idle(1);
    chk(shift_q == 8'hA1, "R3", "byte1 loaded", shift_q, 8'hA1);
    host_wr(2'd0, 8'h10);
    idle(1);
    chk(shift_q == 8'hB2, "R3", "byte2 loaded", shift_q, 8'hB2);
    chk(hs_port[3] == 1'b1, "R4", "request high drained", hs_port[3], 1);
    chk(rd_byte == 8'h00, "R9", "rd_byte zero drained", rd_byte, 0);
    clr_flag();
    host_wr(2'd0, 8'h00);
    idle(1);
    chk(sr_flag == 1'b0, "R3", "no flag when drained", sr_flag, 0);
    chk(shift_q == 8'hB2, "R3", "shift held drained", shift_q, 8'hB2);

    // outbound packet of 18 bytes: last two dropped
    host_wr(2'd1, 8'h10);
    for (int k = 0; k < 18; k++) begin
      host_wr(2'd2, (k == 0) ? 8'h01 : 8'(8'h40 + k));
      if (k == 17) clr_flag();
      toggle_ack();
      if (k == 0) begin
        idle(1);
        chk(sr_flag == 1'b1, "R5", "flag on outbound byte", sr_flag, 1);
      end
    end
    idle(1);
    chk(sr_flag == 1'b1, "R6", "flag on dropped byte", sr_flag, 1);
    host_wr(2'd1, 8'h00);
    idle(2);
    chk(got_cnt == 1, "R7", "one packet delivered", got_cnt, 1);
    chk(got_len == 16, "R6", "length capped", got_len, 16);
    chk(got_data[7:0] == 8'h01, "R5", "outbound byte0", got_data[7:0], 8'h01);
    chk(got_data[127:120] == 8'h4F, "R6", "outbound byte15", got_data[127:120], 8'h4F);

    // empty packet: no strobe
    host_wr(2'd1, 8'h10);
    host_wr(2'd1, 8'h00);
    idle(2);
    chk(got_cnt == 1, "R7", "empty packet silent", got_cnt, 1);

    // two-byte packet: count restarted
    host_wr(2'd1, 8'h10);
    host_wr(2'd2, 8'h01); toggle_ack();
    host_wr(2'd2, 8'h24); toggle_ack();
    host_wr(2'd1, 8'h00);
    idle(2);
    chk(got_cnt == 2, "R7", "second packet", got_cnt, 2);
    chk(got_len == 2, "R7", "index restarted", got_len, 2);
    chk(got_data[15:0] == 16'h2401, "R7", "short packet bytes", got_data[15:0], 16'h2401);

    // R11 host shift write, then collision with an inbound load
    host_wr(2'd2, 8'h77);
    idle(1);
    chk(shift_q == 8'h77, "R11", "host shift write", shift_q, 8'h77);
    put_bytes('{8'h04, 8'hC3});
    commit(2);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0;
    wr_data = (cur_port[4] || cur_port[5]) ? 8'h00 : 8'h10; cur_port = wr_data;
    @(negedge clk);
    wr_addr = 2'd2; wr_data = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0;
    idle(1);
    chk(shift_q == 8'h04, "R11", "inbound load beats host write", shift_q, 8'h04);
    chk(rd_byte == 8'hC3, "R11", "read pos after collision", rd_byte, 8'hC3);

    // R8 commit beats a simultaneous handshake
    pk = '{8'h02, 8'hD5, 8'hE6};
    foreach (pk[i]) begin
      @(negedge clk); ld_wr = 1'b1; ld_addr = 7'(i + 8); ld_data = 8'(pk[i]);
    end
    @(negedge clk); ld_wr = 1'b0;
    put_bytes('{8'h03});
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0;
    wr_data = (cur_port[4] || cur_port[5]) ? 8'h00 : 8'h10; cur_port = wr_data;
    @(negedge clk);
    wr_en = 1'b0; ld_commit = 1'b1; ld_len = 8'd1;
    @(negedge clk);
    ld_commit = 1'b0;
    idle(1);
    chk(shift_q == 8'h04, "R8", "no byte moved on commit", shift_q, 8'h04);
    chk(rd_byte == 8'h03, "R8", "read pos reset", rd_byte, 8'h03);
    chk(hs_port[3] == 1'b0, "R4", "request low new packet", hs_port[3], 0);

    // R10 set wins over clear
    clr_flag();
    @(negedge clk);
    ld_commit = 1'b1; ld_len = 8'd1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h04;
    @(negedge clk);
    ld_commit = 1'b0; wr_en = 1'b0;
    idle(1);
    chk(sr_flag == 1'b1, "R10", "set beats clear", sr_flag, 1);
    host_wr(2'd3, 8'hFB);          // bit 2 clear: no effect
    idle(1);
    chk(sr_flag == 1'b1, "R10", "clear needs bit 2", sr_flag, 1);
    clr_flag();
    idle(1);
    chk(sr_flag == 1'b0, "R10", "clear alone", sr_flag, 0);

    idle(3);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule